// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block sits between a CAN protocol engine and the CPU register bus. The engine drives single-cycle event pulses and loads new values into the transmit and receive error counters. The block turns those inputs into three registers: a sticky error-flag register, a matching per-flag enable register, and an error-code register that records which kinds of protocol error were seen. The warning, passive and bus-off flags come from the counter values crossing fixed thresholds. The engine only reports the counts; the block derives these three flags itself.

Software clears a flag by writing 0 to its bit. Bits written as 1 keep their value. The error-code register has two modes, chosen by its bit 7. In latest mode it holds only the code of the most recent bus error. In accumulate mode it collects every code seen until software clears it. The enabled flags are ORed into one error-interrupt status bit. A separate interrupt-enable bit gates that status bit onto the interrupt line.

Top module: `can_err_capture`

## Requirements
- R1: After reset, every register output, both counters, the interrupt status and the interrupt line are 0.
- R2: The event pulses set error-flag bits in the cycle after the pulse: bus lock sets bit 7, overload frame sent sets bit 6, receive overrun sets bit 5, bus-off recovery sets bit 4, and bus error sets bit 0.
- R3: A write to the error-flag register (address 0) or the error-code register (address 2) clears each flag bit written as 0 and leaves each bit written as 1 unchanged. The enable register (address 1) and the interrupt-enable register (address 3) are plain read/write registers.
- R4: If an event arrives in the same cycle as a write-0 clear of the same flag, the flag ends up set.
- R5: Error-flag bit 1 (warning) sets when the larger of the two counters rises from below 96 to 96 or above. A counter load that stays above the threshold does not set it.
- R6: Error-flag bit 2 (passive) sets when the larger of the two counters rises from below 128 to 128 or above.
- R7: Error-flag bit 3 (bus-off entry) sets when the transmit count changes from at most 255 to above 255. The transmit count input is 9 bits wide, and its 8-bit register output saturates at 255.
- R8: Error-code layout: bit 6 ACK delimiter, bit 5 dominant bit error, bit 4 recessive bit error, bit 3 CRC, bit 2 ACK, bit 1 form, bit 0 stuff, bit 7 mode. When bit 7 is 0 (latest mode), a bus error replaces bits 6:0 with the incoming code.
- R9: When code bit 7 is 1 (accumulate mode), a bus error ORs the incoming code into bits 6:0. Bit 7 takes the written value on every write to address 2.
- R10: The interrupt status is the OR of the error flags ANDed with their enables. The interrupt line is the status ANDed with bit 5 of the interrupt-enable register.
- R11: The counter outputs show the last values the engine loaded, in the cycle after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_bus_lock | input | 1 | Bus lock event pulse |
| ev_overload | input | 1 | Overload frame sent pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_bo_recover | input | 1 | Bus-off recovery pulse |
| ev_bus_err | input | 1 | Bus error pulse, qualifies err_kind |
| err_kind | input | 7 | Error kinds seen in this bus error |
| tec_we | input | 1 | Load transmit count |
| tec_in | input | 9 | New transmit count (bit 8 = above 255) |
| rec_we | input | 1 | Load receive count |
| rec_in | input | 8 | New receive count |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 2 | 0 flags, 1 enables, 2 code, 3 interrupt enable |
| wr_data | input | 8 | Write data |
| flag_q | output | 8 | Error-flag register |
| flag_en_q | output | 8 | Flag enable register |
| code_q | output | 8 | Error-code register |
| irq_en_q | output | 8 | Interrupt-enable register |
| tec_q | output | 8 | Transmit error count, saturated |
| rec_q | output | 8 | Receive error count |
| irq_stat | output | 1 | Error interrupt status |
| irq | output | 1 | Error interrupt line |

## Verification
The bench checks register values one cycle after each stimulus, so a wrong internal state shows up on the ports within one clock. A threshold that is compared against the new count instead of the old one would set a flag again on a load that stays above the threshold, and that shows at once in flag_q. A mode bit handled the wrong way would make code_q either keep stale kinds or lose earlier ones on the second bus error. A clear that overrides an event would leave a flag low right after a same-cycle collision.

// File: rtl/can_err_capture.sv
module can_err_capture #(
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_bus_lock,
  input  logic       ev_overload,
  input  logic       ev_overrun,
  input  logic       ev_bo_recover,
  input  logic       ev_bus_err,
  input  logic [6:0] err_kind,
  input  logic       tec_we,
  input  logic [8:0] tec_in,
  input  logic       rec_we,
  input  logic [7:0] rec_in,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] flag_q,
  output logic [7:0] flag_en_q,
  output logic [7:0] code_q,
  output logic [7:0] irq_en_q,
  output logic [7:0] tec_q,
  output logic [7:0] rec_q,
  output logic       irq_stat,
  output logic       irq
);

  logic [8:0] tec_r, tec_nxt;
  logic [7:0] rec_r, rec_nxt;
  logic       warn_now, warn_nxt, pass_now, pass_nxt;
  logic [7:0] flag_set, flag_keep;
  logic [6:0] code_keep;

  assign tec_nxt  = tec_we ? tec_in : tec_r;
  assign rec_nxt  = rec_we ? rec_in : rec_r;
  assign warn_now = (tec_r >= 9'(WARN_LVL))   || (rec_r >= 8'(WARN_LVL));
  assign warn_nxt = (tec_nxt >= 9'(WARN_LVL)) || (rec_nxt >= 8'(WARN_LVL));
  assign pass_now = (tec_r >= 9'(PASS_LVL))   || (rec_r >= 8'(PASS_LVL));
  assign pass_nxt = (tec_nxt >= 9'(PASS_LVL)) || (rec_nxt >= 8'(PASS_LVL));

  assign flag_set = {ev_bus_lock, ev_overload, ev_overrun, ev_bo_recover,
                     tec_nxt[8] & ~tec_r[8],
                     pass_nxt & ~pass_now,
                     warn_nxt & ~warn_now,
                     ev_bus_err};

  assign flag_keep = (wr_en && wr_addr == 2'd0) ? wr_data : 8'hFF;
  assign code_keep = (wr_en && wr_addr == 2'd2) ? wr_data[6:0] : 7'h7F;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec_r     <= '0;
      rec_r     <= '0;
      flag_q    <= '0;
      flag_en_q <= '0;
      code_q    <= '0;
      irq_en_q  <= '0;
    end else begin
      tec_r  <= tec_nxt;
      rec_r  <= rec_nxt;
      flag_q <= (flag_q & flag_keep) | flag_set;
      if (wr_en && wr_addr == 2'd1) flag_en_q <= wr_data;
      if (wr_en && wr_addr == 2'd3) irq_en_q  <= wr_data;
      if (wr_en && wr_addr == 2'd2) code_q[7] <= wr_data[7];
      if (ev_bus_err && !code_q[7])
        code_q[6:0] <= err_kind;
      else if (ev_bus_err)
        code_q[6:0] <= (code_q[6:0] & code_keep) | err_kind;
      else
        code_q[6:0] <= code_q[6:0] & code_keep;
    end
  end

  assign tec_q    = tec_r[8] ? 8'hFF : tec_r[7:0];
  assign rec_q    = rec_r;
  assign irq_stat = |(flag_q & flag_en_q);
  assign irq      = irq_stat & irq_en_q[5];

  a_r2_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_lock |=> flag_q[7]);
  a_r2_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> flag_q[5]);
  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_err && wr_en && wr_addr == 2'd0 && !wr_data[0]) |=> flag_q[0]);
  a_r3_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[6] && !(wr_en && wr_addr == 2'd0)) |=> flag_q[6]);
  a_r8_latest_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_err && !code_q[7] && !(wr_en && wr_addr == 2'd2)) |=> code_q[6:0] == $past(err_kind));
  a_r9_accum_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_err && code_q[7] && !(wr_en && wr_addr == 2'd2)) |=> (code_q[6:0] & $past(code_q[6:0])) == $past(code_q[6:0]));
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en_q[5] && (flag_q & flag_en_q) != 8'h00));
  a_r7_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_we && tec_in[8] && tec_q != 8'hFF) |=> (flag_q[3] && tec_q == 8'hFF));

endmodule

// File: tb/can_err_capture_tb_top.sv
module can_err_capture_tb_top;
  logic clk = 0, rst_n = 0;
  logic ev_bus_lock = 0, ev_overload = 0, ev_overrun = 0, ev_bo_recover = 0, ev_bus_err = 0;
  logic [6:0] err_kind = 0;
  logic tec_we = 0, rec_we = 0, wr_en = 0;
  logic [8:0] tec_in = 0;
  logic [7:0] rec_in = 0, wr_data = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] flag_q, flag_en_q, code_q, irq_en_q, tec_q, rec_q;
  logic irq_stat, irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  can_err_capture dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
    {ev_bus_lock, ev_overload, ev_overrun, ev_bo_recover, ev_bus_err} = '0;
    {tec_we, rec_we, wr_en} = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic ld_tec(input logic [8:0] v); tec_we = 1; tec_in = v; step(); endtask
  task automatic ld_rec(input logic [7:0] v); rec_we = 1; rec_in = v; step(); endtask
  task automatic berr(input logic [6:0] k); ev_bus_err = 1; err_kind = k; step(); endtask

  task automatic t_reset;
    chk("R1 flags", flag_q, 0); chk("R1 code", code_q, 0);
    chk("R1 en", {flag_en_q, irq_en_q}, 0); chk("R1 counters", {tec_q, rec_q}, 0);
    chk("R1 irq", {irq_stat, irq}, 0);
  endtask

  task automatic t_events;
    ev_bus_lock = 1; step(); chk("R2 bus lock bit7", flag_q, 8'h80);
    ev_overrun = 1; ev_bo_recover = 1; step(); chk("R2 overrun+recover", flag_q, 8'hB0);
    ev_overload = 1; step(); chk("R2 overload bit6", flag_q, 8'hF0);
    wr(0, 8'h7F); chk("R3 clear bit7", flag_q, 8'h70);
    wr(0, 8'hFF); chk("R3 ones keep", flag_q, 8'h70);
    wr(0, 8'h00); chk("R3 clear all", flag_q, 8'h00);
  endtask

  task automatic t_collide;
    ev_overload = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h00; step();
    chk("R4 event beats clear", flag_q, 8'h40);
    wr(0, 8'h00);
  endtask

  task automatic t_thresholds;
    ld_tec(95); chk("R5 below warn", flag_q, 8'h00); chk("R11 tec", tec_q, 95);
    ld_tec(96); chk("R5 warn crossing", flag_q, 8'h02);
    wr(0, 8'h00); ld_tec(100); chk("R5 no re-set above", flag_q, 8'h00);
    ld_tec(0); ld_rec(130); chk("R6 warn+passive via rec", flag_q, 8'h06);
    chk("R11 rec", rec_q, 130);
    wr(0, 8'h00); ld_tec(256); chk("R7 bus-off entry", flag_q, 8'h08);
    chk("R7 tec saturates", tec_q, 8'hFF);
    ld_tec(0); ld_rec(0); wr(0, 8'h00);
  endtask

  task automatic t_codes;
    berr(7'h08); chk("R8 latest first", code_q, 8'h08); chk("R2 bus err bit0", flag_q, 8'h01);
    berr(7'h01); chk("R8 latest replaces", code_q, 8'h01);
    wr(2, 8'h80); chk("R9 mode set, code cleared", code_q, 8'h80);
    berr(7'h04); berr(7'h20); chk("R9 accumulate", code_q, 8'hA4);
    wr(2, 8'hFB); chk("R3 code clear bit2", code_q, 8'hA0);
  endtask

  task automatic t_irq;
    chk("R10 masked", {irq_stat, irq}, 2'b00);
    wr(1, 8'h01); chk("R10 status no line", {irq_stat, irq}, 2'b10);
    wr(3, 8'h20); chk("R10 line on", {irq_stat, irq}, 2'b11);
    wr(0, 8'h00); chk("R10 cleared", {irq_stat, irq}, 2'b00);
  endtask

  initial begin
    fork
      begin
        @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset(); t_events(); t_collide(); t_thresholds(); t_codes(); t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule